// File: doc/BRIEF.md
# Configurable Serial Frame Transmitter

This block turns one data word into one serial character on a single transmit line. A control word sets the format of the next character: free-running (oversampled) or clocked operation, 5 to 9 data bits, parity off, even or odd, and one or two stop bits. The line idles high. Each frame carries a low start bit, then the data bits least significant first, then the parity bit if parity is on, then one or two high stop bits.

In free-running operation a bit lasts sixteen pulses of an external rate tick. In clocked operation, bits move on edges of an external transfer clock, and a polarity bit picks which edge is active. The format and the data word are captured when a request is accepted, so later changes to the inputs do not touch the frame already on the line. `busy` is high while a frame is being sent. `done` pulses for one cycle when the last stop bit ends.

Top module: `usart_frame_tx`

## Requirements
- R1: While no frame is being sent (including right after reset), `tx_line` is 1, `busy` is 0 and `done` is 0.
- R2: A `start` pulse seen while idle with operating mode 00 or 01 raises `busy`, and drives the start bit (0) on `tx_line`, from the next cycle.
- R3: The data bits follow the start bit, least significant first. The size code {`size_msb`, `ctrl[2:1]`} selects the count: 000→5, 001→6, 010→7, 011→8, 111→9. The reserved codes 100, 101 and 110 give 8 bits.
- R4: Parity code `ctrl[5:4]` = 10 adds one bit after the data that makes the count of ones over data and parity even. Code 11 makes that count odd. Codes 00 and 01 add no parity bit.
- R5: Stop select `ctrl[3]` = 0 ends the frame with one high stop bit. A value of 1 ends it with two.
- R6: In mode 00 (free-running), each bit lasts exactly 16 cycles in which `baud_tick` is 1. Edges of `xfer_clk` have no effect.
- R7: In mode 01 (clocked), the line moves to the next bit on each rising edge of `xfer_clk` when polarity `ctrl[0]` = 0, or on each falling edge when it is 1. Inactive edges and `baud_tick` have no effect.
- R8: `done` is 1 for exactly one cycle: the first cycle after the last stop bit ends, which is also the cycle in which `busy` returns to 0.
- R9: While `busy` is 1, `start`, `tx_data` and `ctrl` changes do not alter the frame in progress, and no second frame follows it.
- R10: A `start` pulse with operating mode 10 (reserved) or 11 (master-SPI code, not supported here) is ignored: `busy` stays 0 and `tx_line` stays 1.
- R11: The control word is laid out as `ctrl[7:6]` operating mode, `ctrl[5:4]` parity, `ctrl[3]` stop select, `ctrl[2:1]` low size-code bits and `ctrl[0]` clock polarity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl | input | 8 | Frame format control word |
| size_msb | input | 1 | Most significant bit of the size code |
| tx_data | input | 9 | Character to send |
| start | input | 1 | Request to send one frame |
| baud_tick | input | 1 | Rate tick for free-running mode |
| xfer_clk | input | 1 | Transfer clock for clocked mode |
| tx_line | output | 1 | Serial transmit line |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |

## Verification
A wrong bit counter or a bad shift-register load shows up as a wrong level on `tx_line`, in the middle of the first bit it affects. A bad frame length shows as `done` arriving one bit-time early or late. A wrong tick divider or a wrong edge selector moves every bit boundary, so the error shows within the first data bit after the start bit. A missing start or a missing capture of the format makes `busy` or the start bit wrong in the cycle right after the request.

// File: rtl/usart_frame_tx.sv
module usart_frame_tx #(
  parameter int OVERSAMPLE = 16,
  parameter int MAXDATA    = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [7:0]         ctrl,
  input  logic               size_msb,
  input  logic [MAXDATA-1:0] tx_data,
  input  logic               start,
  input  logic               baud_tick,
  input  logic               xfer_clk,
  output logic               tx_line,
  output logic               busy,
  output logic               done
);
  localparam int FRAME_W = MAXDATA + 4;
  localparam int TCW     = $clog2(OVERSAMPLE);
  localparam int NW      = $clog2(FRAME_W + 1);

  logic [8:0]         fmt_q;
  logic [FRAME_W-1:0] shreg, frame_d;
  logic [NW-1:0]      left, nbits_d;
  logic [TCW-1:0]     tcnt;
  logic [3:0]         size_n;
  logic               xprev, par, accept, xedge, step;

  wire sync_q = fmt_q[6];
  wire pol_q  = fmt_q[0];

  assign accept = start && !busy && !ctrl[7];
  assign xedge  = pol_q ? (xprev & ~xfer_clk) : (~xprev & xfer_clk);
  assign step   = busy && (sync_q ? xedge : (baud_tick && tcnt == TCW'(OVERSAMPLE - 1)));
  assign tx_line = busy ? shreg[0] : 1'b1;

  always_comb begin
    case ({size_msb, ctrl[2:1]})
      3'b000:  size_n = 4'd5;
      3'b001:  size_n = 4'd6;
      3'b010:  size_n = 4'd7;
      3'b111:  size_n = 4'd9;
      default: size_n = 4'd8;
    endcase
    frame_d    = '1;
    frame_d[0] = 1'b0;
    par        = ctrl[4];
    for (int i = 0; i < MAXDATA; i++) begin
      if (i < int'(size_n)) begin
        frame_d[i+1] = tx_data[i];
        par          = par ^ tx_data[i];
      end
    end
    if (ctrl[5]) frame_d[size_n+1] = par;
    nbits_d = NW'(size_n) + NW'(2) + NW'(ctrl[5]) + NW'(ctrl[3]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fmt_q <= 9'h006;
      shreg <= '1;
      left  <= '0;
      tcnt  <= '0;
      xprev <= 1'b0;
      busy  <= 1'b0;
      done  <= 1'b0;
    end else begin
      xprev <= xfer_clk;
      done  <= 1'b0;
      if (accept) begin
        fmt_q <= {size_msb, ctrl};
        shreg <= frame_d;
        left  <= nbits_d;
        tcnt  <= '0;
        busy  <= 1'b1;
      end else if (busy) begin
        if (!sync_q && baud_tick)
          tcnt <= (tcnt == TCW'(OVERSAMPLE - 1)) ? '0 : tcnt + 1'b1;
        if (step) begin
          if (left == NW'(1)) begin
            busy <= 1'b0;
            done <= 1'b1;
          end else begin
            shreg <= {1'b1, shreg[FRAME_W-1:1]};
            left  <= left - 1'b1;
          end
        end
      end
    end
  end
endmodule

module usart_frame_tx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] ctrl,
  input logic       start,
  input logic       baud_tick,
  input logic       xfer_clk,
  input logic       tx_line,
  input logic       busy,
  input logic       done
);
  p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> tx_line);
  p_start_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !ctrl[7]) |=> (busy && !tx_line));
  p_reserved_mode_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && ctrl[7]) |=> !busy);
  p_done_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $fell(busy));
  p_step_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && tx_line != $past(tx_line)) |->
      ($past(baud_tick) || $past(xfer_clk) != $past(xfer_clk, 2)));
endmodule

bind usart_frame_tx usart_frame_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .start(start), .baud_tick(baud_tick),
  .xfer_clk(xfer_clk), .tx_line(tx_line), .busy(busy), .done(done)
);

// File: tb/usart_frame_tx_bench.sv
`timescale 1ns/1ps
module usart_frame_tx_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] ctrl = 8'h06;
  logic size_msb = 1'b0, start = 1'b0, baud_tick = 1'b0, xfer_clk = 1'b0;
  logic [8:0] tx_data = '0;
  logic tx_line, busy, done;
  int n_run = 0, n_fail = 0, tick_div = 1, tick_cnt = 0;
  bit finished = 0;

  usart_frame_tx u_usart_frame_tx (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .size_msb(size_msb), .tx_data(tx_data),
    .start(start), .baud_tick(baud_tick), .xfer_clk(xfer_clk),
    .tx_line(tx_line), .busy(busy), .done(done)
  );

  always #2.5 clk = ~clk;

  always @(negedge clk) begin
    baud_tick <= (tick_div != 0) && (tick_cnt == 0);
    tick_cnt  <= (tick_div != 0 && tick_cnt + 1 < tick_div) ? tick_cnt + 1 : 0;
  end

  task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int expect_frame(input [8:0] d, input [2:0] sc, input [1:0] pm,
                                      input logic st, output logic [12:0] bits);
    int n;
    logic [8:0] m;
    n = (sc == 3'b111) ? 9 : (sc[2] ? 8 : 5 + int'(sc[1:0]));
    m = 9'h1FF >> (9 - n);
    bits = '1;
    bits[0] = 1'b0;
    for (int k = 0; k < n; k++) bits[k+1] = d[k];
    if (pm == 2'b10) bits[n+1] = ($countones(d & m) % 2) == 1;
    if (pm == 2'b11) bits[n+1] = ($countones(d & m) % 2) == 0;
    return n + 2 + int'(pm[1]) + int'(st);
  endfunction

  task automatic wait_ticks(input int k);
    int got = 0;
    while (got < k) begin
      @(posedge clk);
      if (baud_tick) got++;
      #1 start = 1'b0;
    end
  endtask

  task automatic send_start(input [7:0] c, input logic msb, input [8:0] d);
    @(negedge clk);
    ctrl = c; size_msb = msb; tx_data = d; start = 1'b1;
    @(posedge clk);
    #1 start = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(tx_line === 1'b1 && busy === 1'b0 && done === 1'b0, "R1", "idle after reset",
          {tx_line, busy, done}, 3'b100);
  endtask

  task automatic t_async(input [7:0] c, input logic msb, input [8:0] d, input int div,
                         input bit disturb, input string tag);
    logic [12:0] bits;
    int len, bad;
    len = expect_frame(d, {msb, c[2:1]}, c[5:4], c[3], bits);
    tick_div = div;
    bad = 0;
    send_start(c, msb, d);
    check(busy === 1'b1 && tx_line === 1'b0, "R2", "busy/start bit", {busy, tx_line}, 2'b10);
    wait_ticks(8);
    @(negedge clk);
    for (int b = 0; b < len; b++) begin
      if (b > 0) begin
        wait_ticks(16);
        @(negedge clk);
      end
      if (tx_line !== bits[b]) begin
        bad++;
        $display("FAIL %s bit %0d: tx=%b expected %b", tag, b, tx_line, bits[b]);
      end
      if (disturb && b == 3) begin
        start = 1'b1; tx_data = ~d; ctrl = 8'h79; size_msb = ~msb;
      end
    end
    n_run++;
    if (bad != 0) n_fail++;
    wait_ticks(8);
    @(negedge clk);
    check(done === 1'b1 && busy === 1'b0, "R8", "done at frame end (R6 length)", {done, busy}, 2'b10);
    @(negedge clk);
    check(done === 1'b0, "R8", "done width", done, 0);
    if (disturb) begin
      repeat (40) @(negedge clk);
      check(busy === 1'b0 && tx_line === 1'b1, "R9", "no second frame", {busy, tx_line}, 2'b01);
    end
  endtask

  task automatic t_sync(input [7:0] c, input logic msb, input [8:0] d, input string tag);
    logic [12:0] bits;
    int len, bad;
    len = expect_frame(d, {msb, c[2:1]}, c[5:4], c[3], bits);
    tick_div = 1;
    bad = 0;
    @(negedge clk);
    xfer_clk = c[0];
    repeat (3) @(negedge clk);
    send_start(c, msb, d);
    for (int b = 0; b < len; b++) begin
      @(negedge clk);
      if (tx_line !== bits[b]) begin
        bad++;
        $display("FAIL %s bit %0d: tx=%b expected %b", tag, b, tx_line, bits[b]);
      end
      xfer_clk = ~c[0];
      @(negedge clk);
      if (b == len - 1)
        check(done === 1'b1 && busy === 1'b0, "R8", "sync done", {done, busy}, 2'b10);
      repeat (3) @(negedge clk);
      xfer_clk = c[0];
      repeat (3) @(negedge clk);
    end
    n_run++;
    if (bad != 0) n_fail++;
    check(busy === 1'b0 && tx_line === 1'b1, "R1", "idle after sync frame", {busy, tx_line}, 2'b01);
  endtask

  task automatic t_reserved_mode(input [7:0] c);
    int bad = 0;
    send_start(c, 1'b0, 9'h000);
    repeat (20) begin
      @(negedge clk);
      if (busy !== 1'b0 || tx_line !== 1'b1) bad++;
    end
    check(bad == 0, "R10", "reserved mode start ignored", bad, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_async(8'h06, 1'b0, 9'h0A5, 1, 0, "R3/R6/R11 8N1");
    t_async(8'h28, 1'b0, 9'h01B, 3, 0, "R4/R5 5E2");
    t_async(8'h36, 1'b1, 9'h1C3, 2, 0, "R3/R4 9O1");
    t_async(8'h10, 1'b1, 9'h15A, 1, 0, "R3/R4 reserved codes");
    t_async(8'h3A, 1'b0, 9'h02D, 1, 1, "R9 6O2 disturbed");
    t_sync(8'h66, 1'b0, 9'h096, "R7 pol0 8E1");
    t_sync(8'h4D, 1'b0, 9'h055, "R7 pol1 7N2");
    t_reserved_mode(8'h86);
    t_reserved_mode(8'hC6);
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule